// File: doc/BRIEF.md
# Framer Error-Counter Accumulation Latch

This block collects error events reported by a T1 or E1 receive framer into three live counters. At the end of each accumulation window it copies the live values into holding registers that the host reads, and it restarts the live counters from zero. The three counters cover line-code violations, path-code (framing-bit) errors, and either framing-bit errors or multiframe out-of-sync events.

The window is set in one of two ways. A frame-count timer can close it, with a long or a short interval whose length depends on the line mode. Software can also close it by raising a trigger bit in the control field. Control bits choose what each counter counts. All ports are plain control and status pins. Error events are single-cycle pulses qualified by the receive clock, and no port carries a flow-controlled data stream, so there is no valid/ready handshake and no back-pressure.

The control field `cfg_reg` has these bits:

| Bit | Use |
|-----|-----|
| 0 | In T1 mode, 1 adds excessive-zeros events to the line-code count. |
| 1 | 0 makes the third counter count framing-bit errors; 1 makes it count multiframe out-of-sync events. |
| 2 | 1 adds Fs-bit errors to the path-code count. |
| 3 | In E1 mode, 0 makes the line-code counter count bipolar violations; 1 makes it count code violations. |
| 4 | 0 selects timer control of the window; 1 selects manual control. |
| 5 | Selects the timer interval: 0 is long, 1 is short. |
| 6 | Manual trigger. |

Top module: `ferr_accum_latch`

## Requirements
- R1: After reset, all three held counts read 0 and `update_done` is 0.
- R2: With `cfg_reg[4]`=0 and `cfg_reg[5]`=0, a latch happens on the 8000th frame-start strobe counted since the timer restarted, in both T1 and E1 modes.
- R3: With `cfg_reg[4]`=0 and `cfg_reg[5]`=1, the latch comes on the 333rd strobe in T1 mode (`e1_mode`=0) and on the 500th strobe in E1 mode (`e1_mode`=1).
- R4: With `cfg_reg[4]`=1, a 0-to-1 change of `cfg_reg[6]` latches at the next clock edge, and frame strobes cause no latch. With `cfg_reg[4]`=0, changes of `cfg_reg[6]` have no effect.
- R5: In E1 mode, the line-code counter counts `bpv_evt` when `cfg_reg[3]`=0 and counts `cv_evt` when `cfg_reg[3]`=1.
- R6: In T1 mode, the line-code counter counts `bpv_evt`, plus `exz_evt` when `cfg_reg[0]`=1. `cv_evt` is never counted in T1 mode. Two events in the same cycle add 2.
- R7: The path-code counter counts `ft_err_evt`, plus `fs_err_evt` when `cfg_reg[2]`=1. Two events in the same cycle add 2.
- R8: The third counter counts `fbe_evt` when `cfg_reg[1]`=0 and counts `mf_oos_evt` when `cfg_reg[1]`=1.
- R9: A live counter stops at all-ones (2^CNT_W-1) and does not wrap.
- R10: At a latch, the held value is the count before that cycle's events. An event in the latch cycle is counted in the new window.
- R11: Any change of `e1_mode`, `cfg_reg[5]` or `cfg_reg[4]` restarts the frame timer from zero.
- R12: `update_done` is high for exactly one cycle after each latch. The held counts change only together with that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One-cycle pulse at each frame start |
| e1_mode | input | 1 | 1 = E1 line, 0 = T1 line |
| cfg_reg | input | 7 | Control field; bit meanings are listed above |
| bpv_evt | input | 1 | Bipolar violation pulse |
| cv_evt | input | 1 | Code violation pulse |
| exz_evt | input | 1 | Excessive-zeros pulse |
| ft_err_evt | input | 1 | Ft framing-bit error pulse |
| fs_err_evt | input | 1 | Fs framing-bit error pulse |
| fbe_evt | input | 1 | Framing-bit error pulse for the third counter |
| mf_oos_evt | input | 1 | Multiframe out-of-sync pulse |
| lcv_count | output | CNT_W | Held line-code count |
| pcv_count | output | CNT_W | Held path-code count |
| mos_count | output | CNT_W | Held framing / multiframe count |
| update_done | output | 1 | One-cycle pulse after each latch |

## Verification
The assertions assume that the manual trigger bit, once high, falls before it can rise again. They also assume that frame strobes are far enough apart that two timer latches never fall on adjacent cycles, that control changes are synchronous to the receive clock, and that each error input is a clean one-cycle-qualified level. The stimulus changes every input at the falling clock edge. It returns the trigger bit low right after each manual latch, and it uses only timer intervals of hundreds of strobes. Before each timed window, a manual-mode excursion restarts the timer and clears the live counts, so every window starts from a known state.

// File: rtl/ferr_pkg.sv
package ferr_pkg;

  localparam int unsigned INC_W   = 2;
  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned IDX_LCV = 0;
  localparam int unsigned IDX_PCV = 1;
  localparam int unsigned IDX_MOS = 2;

  localparam int unsigned B_EXZ_INCL = 0;
  localparam int unsigned B_MF_SEL   = 1;
  localparam int unsigned B_FS_INCL  = 2;
  localparam int unsigned B_CV_SEL   = 3;
  localparam int unsigned B_MAN_MODE = 4;
  localparam int unsigned B_SHORT    = 5;
  localparam int unsigned B_MAN_TRIG = 6;

  typedef struct packed {
    logic man_trig;
    logic short_win;
    logic man_mode;
    logic e1_cv_sel;
    logic fs_incl;
    logic mf_sel;
    logic exz_incl;
  } ferr_cfg_t;

  function automatic ferr_cfg_t ferr_decode(input logic [6:0] r);
    ferr_cfg_t c;
    c.man_trig  = r[B_MAN_TRIG];
    c.short_win = r[B_SHORT];
    c.man_mode  = r[B_MAN_MODE];
    c.e1_cv_sel = r[B_CV_SEL];
    c.fs_incl   = r[B_FS_INCL];
    c.mf_sel    = r[B_MF_SEL];
    c.exz_incl  = r[B_EXZ_INCL];
    return c;
  endfunction

endpackage

// File: rtl/ferr_interval_timer.sv
module ferr_interval_timer #(
  parameter int unsigned FRAMES_LONG     = 8000,
  parameter int unsigned FRAMES_T1_SHORT = 333,
  parameter int unsigned FRAMES_E1_SHORT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_strobe,
  input  logic e1_mode,
  input  logic short_win,
  input  logic man_mode,
  output logic tick
);
  localparam int unsigned CW = $clog2(FRAMES_LONG + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic [2:0]    key, key_q;
  logic          key_chg;

  always_comb begin
    if (!short_win)   limit = CW'(FRAMES_LONG);
    else if (e1_mode) limit = CW'(FRAMES_E1_SHORT);
    else              limit = CW'(FRAMES_T1_SHORT);
  end

  assign key     = {e1_mode, short_win, man_mode};
  assign key_chg = (key != key_q);
  assign tick    = frame_strobe && !man_mode && !key_chg &&
                   (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      key_q <= '0;
    end else begin
      key_q <= key;
      if (man_mode || key_chg)  cnt_q <= '0;
      else if (frame_strobe)    cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !key_chg |-> (cnt_q < limit)); // R3
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/ferr_edge_trigger.sv
module ferr_edge_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic enable,
  output logic rise_pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise_pulse = enable && level && !prev_q;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R4

endmodule

// File: rtl/ferr_event_select.sv
module ferr_event_select
  import ferr_pkg::*;
(
  input  ferr_cfg_t        cfg,
  input  logic             e1_mode,
  input  logic             bpv_evt,
  input  logic             cv_evt,
  input  logic             exz_evt,
  input  logic             ft_err_evt,
  input  logic             fs_err_evt,
  input  logic             fbe_evt,
  input  logic             mf_oos_evt,
  output logic [INC_W-1:0] lcv_inc,
  output logic [INC_W-1:0] pcv_inc,
  output logic [INC_W-1:0] mos_inc
);
  always_comb begin
    if (e1_mode)
      lcv_inc = INC_W'(cfg.e1_cv_sel ? cv_evt : bpv_evt);
    else
      lcv_inc = INC_W'(bpv_evt) + INC_W'(cfg.exz_incl & exz_evt);
    pcv_inc = INC_W'(ft_err_evt) + INC_W'(cfg.fs_incl & fs_err_evt);
    mos_inc = INC_W'(cfg.mf_sel ? mf_oos_evt : fbe_evt);
  end

endmodule

// File: rtl/ferr_sat_counter.sv
module ferr_sat_counter #(
  parameter int unsigned W     = 16,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt_q
);
  localparam int unsigned SW      = W + 1;
  localparam logic [W-1:0] MAXV   = '1;
  localparam int unsigned INC_MAX = (1 << INC_W) - 1;

  logic [SW-1:0] sum;
  assign sum = {1'b0, cnt_q} + SW'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= W'(inc);
    else if (sum[W])             cnt_q <= MAXV;
    else                         cnt_q <= sum[W-1:0];
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV)); // R9
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q <= W'(INC_MAX))); // R10

endmodule

// File: rtl/ferr_accum_latch.sv
module ferr_accum_latch
  import ferr_pkg::*;
#(
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned FRAMES_LONG     = 8000,
  parameter int unsigned FRAMES_T1_SHORT = 333,
  parameter int unsigned FRAMES_E1_SHORT = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_strobe,
  input  logic             e1_mode,
  input  logic [6:0]       cfg_reg,
  input  logic             bpv_evt,
  input  logic             cv_evt,
  input  logic             exz_evt,
  input  logic             ft_err_evt,
  input  logic             fs_err_evt,
  input  logic             fbe_evt,
  input  logic             mf_oos_evt,
  output logic [CNT_W-1:0] lcv_count,
  output logic [CNT_W-1:0] pcv_count,
  output logic [CNT_W-1:0] mos_count,
  output logic             update_done
);
  ferr_cfg_t        cfg;
  logic             timer_tick, man_rise, latch;
  logic [INC_W-1:0] inc  [NUM_CNT];
  logic [CNT_W-1:0] live [NUM_CNT];
  logic [CNT_W-1:0] hold [NUM_CNT];

  assign cfg = ferr_decode(cfg_reg);

  ferr_interval_timer #(
    .FRAMES_LONG    (FRAMES_LONG),
    .FRAMES_T1_SHORT(FRAMES_T1_SHORT),
    .FRAMES_E1_SHORT(FRAMES_E1_SHORT)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_strobe(frame_strobe),
    .e1_mode     (e1_mode),
    .short_win   (cfg.short_win),
    .man_mode    (cfg.man_mode),
    .tick        (timer_tick)
  );

  ferr_edge_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (cfg.man_trig),
    .enable    (cfg.man_mode),
    .rise_pulse(man_rise)
  );

  ferr_event_select u_sel (
    .cfg       (cfg),
    .e1_mode   (e1_mode),
    .bpv_evt   (bpv_evt),
    .cv_evt    (cv_evt),
    .exz_evt   (exz_evt),
    .ft_err_evt(ft_err_evt),
    .fs_err_evt(fs_err_evt),
    .fbe_evt   (fbe_evt),
    .mf_oos_evt(mf_oos_evt),
    .lcv_inc   (inc[IDX_LCV]),
    .pcv_inc   (inc[IDX_PCV]),
    .mos_inc   (inc[IDX_MOS])
  );

  assign latch = timer_tick | man_rise;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ferr_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (latch),
      .inc  (inc[g]),
      .cnt_q(live[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)     hold[g] <= '0;
      else if (latch) hold[g] <= live[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) update_done <= 1'b0;
    else        update_done <= latch;
  end

  assign lcv_count = hold[IDX_LCV];
  assign pcv_count = hold[IDX_PCV];
  assign mos_count = hold[IDX_MOS];

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> !update_done); // R12
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !update_done |-> ($stable(lcv_count) && $stable(pcv_count) && $stable(mos_count))); // R12
  AST_MANUAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.man_mode && man_rise) |=> update_done); // R4

endmodule

// File: tb/ferr_accum_latch_tb.sv
module ferr_accum_latch_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_strobe = 1'b0;
  logic e1_mode = 1'b0;
  logic [6:0] cfg = 7'd0;
  // event bundle order: {bpv, cv, exz, ft, fs, fbe, mf}
  logic [6:0] evv = 7'd0;
  logic [CW-1:0] lcv_count, pcv_count, mos_count;
  logic update_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [6:0] E_BPV = 7'b1000000;
  localparam logic [6:0] E_CV  = 7'b0100000;
  localparam logic [6:0] E_EXZ = 7'b0010000;
  localparam logic [6:0] E_FT  = 7'b0001000;
  localparam logic [6:0] E_FS  = 7'b0000100;
  localparam logic [6:0] E_FBE = 7'b0000010;
  localparam logic [6:0] E_MF  = 7'b0000001;

  always #4 clk = ~clk;

  ferr_accum_latch #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .e1_mode(e1_mode),
    .cfg_reg(cfg), .bpv_evt(evv[6]), .cv_evt(evv[5]), .exz_evt(evv[4]),
    .ft_err_evt(evv[3]), .fs_err_evt(evv[2]), .fbe_evt(evv[1]), .mf_oos_evt(evv[0]),
    .lcv_count(lcv_count), .pcv_count(pcv_count), .mos_count(mos_count),
    .update_done(update_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] v, input int n);
    @(negedge clk) evv = v;
    repeat (n) @(negedge clk);
    evv = 7'd0;
  endtask

  task automatic latch_check(input string req, input int el, input int ep, input int em);
    @(negedge clk) cfg[6] = 1'b1;
    @(negedge clk);
    chk({req, " done"}, int'(update_done), 1);
    chk({req, " lcv"}, int'(lcv_count), el);
    chk({req, " pcv"}, int'(pcv_count), ep);
    chk({req, " mos"}, int'(mos_count), em);
    cfg[6] = 1'b0;
    @(negedge clk);
    chk("R12 done falls", int'(update_done), 0);
    chk("R12 hold steady", int'(lcv_count), el);
  endtask

  task automatic manual_setup(input logic e1, input logic [3:0] sel);
    @(negedge clk);
    e1_mode = e1;
    cfg = {3'b001, sel};
    @(negedge clk) cfg[6] = 1'b1;
    @(negedge clk) cfg[6] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 lcv", int'(lcv_count), 0);
    chk("R1 pcv", int'(pcv_count), 0);
    chk("R1 mos", int'(mos_count), 0);
    chk("R1 done", int'(update_done), 0);
  endtask

  task automatic t_e1_lcv;
    manual_setup(1'b1, 4'b0000);
    pulse(E_BPV, 3); pulse(E_CV, 2);
    latch_check("R5 bpv sel", 3, 0, 0);
    cfg[3] = 1'b1;
    pulse(E_BPV, 3); pulse(E_CV, 2);
    latch_check("R5 cv sel", 2, 0, 0);
  endtask

  task automatic t_t1_lcv;
    manual_setup(1'b0, 4'b0000);
    pulse(E_BPV, 2); pulse(E_EXZ, 4); pulse(E_CV, 3);
    latch_check("R6 exz off", 2, 0, 0);
    cfg[0] = 1'b1;
    pulse(E_BPV, 2); pulse(E_EXZ, 4); pulse(E_BPV | E_EXZ, 1);
    latch_check("R6 exz on", 8, 0, 0);
  endtask

  task automatic t_pcv;
    manual_setup(1'b0, 4'b0000);
    pulse(E_FT, 3); pulse(E_FS, 2);
    latch_check("R7 fs off", 0, 3, 0);
    cfg[2] = 1'b1;
    pulse(E_FT, 3); pulse(E_FS, 2); pulse(E_FT | E_FS, 1);
    latch_check("R7 fs on", 0, 7, 0);
  endtask

  task automatic t_mos;
    manual_setup(1'b1, 4'b0000);
    pulse(E_FBE, 4); pulse(E_MF, 1);
    latch_check("R8 fbe sel", 0, 0, 4);
    cfg[1] = 1'b1;
    pulse(E_FBE, 4); pulse(E_MF, 1);
    latch_check("R8 mf sel", 0, 0, 1);
  endtask

  task automatic t_sat;
    manual_setup(1'b1, 4'b0000);
    pulse(E_BPV, 300);
    latch_check("R9 saturate", 255, 0, 0);
  endtask

  task automatic t_same_cycle;
    manual_setup(1'b1, 4'b0000);
    pulse(E_BPV, 3);
    @(negedge clk) begin cfg[6] = 1'b1; evv = E_BPV; end
    @(negedge clk);
    evv = 7'd0;
    chk("R10 done", int'(update_done), 1);
    chk("R10 old interval", int'(lcv_count), 3);
    cfg[6] = 1'b0;
    latch_check("R10 new interval", 1, 0, 0);
  endtask

  task automatic t_manual_only;
    int seen = 0;
    manual_setup(1'b0, 4'b0000);
    cfg[5] = 1'b1;
    @(negedge clk) frame_strobe = 1'b1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (update_done) seen++;
    end
    frame_strobe = 1'b0;
    chk("R4 no timer latch in manual", seen, 0);
    cfg[4] = 1'b0;
    @(negedge clk);
    @(negedge clk) cfg[6] = 1'b1;
    seen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (update_done) seen++;
    end
    cfg[6] = 1'b0;
    chk("R4 trigger ignored in timed", seen, 0);
  endtask

  task automatic run_window(input string req, input logic e1, input logic sw, input int len);
    int early = 0;
    @(negedge clk);
    e1_mode = e1;
    cfg = {1'b1, sw, 1'b1, 4'b0000};
    @(negedge clk) cfg = {1'b0, sw, 1'b0, 4'b0000};
    @(negedge clk) begin frame_strobe = 1'b1; evv = E_BPV; end
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (i == 5) evv = 7'd0;
      if (i < len && update_done) early++;
    end
    chk({req, " no early latch"}, early, 0);
    chk({req, " latch at window end"}, int'(update_done), 1);
    chk({req, " count"}, int'(lcv_count), 5);
    frame_strobe = 1'b0;
  endtask

  task automatic t_restart;
    int early = 0;
    @(negedge clk);
    e1_mode = 1'b0;
    cfg = 7'b1110000;
    @(negedge clk) cfg = 7'b0100000;
    @(negedge clk) frame_strobe = 1'b1;
    repeat (200) @(negedge clk);
    frame_strobe = 1'b0;
    e1_mode = 1'b1;
    @(negedge clk) frame_strobe = 1'b1;
    for (int i = 1; i <= 500; i++) begin
      @(negedge clk);
      if (i < 500 && update_done) early++;
    end
    frame_strobe = 1'b0;
    chk("R11 no latch before restart window", early, 0);
    chk("R11 latch 500 after restart", int'(update_done), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_e1_lcv();
    t_t1_lcv();
    t_pcv();
    t_mos();
    t_sat();
    t_same_cycle();
    t_manual_only();
    run_window("R3 T1 short", 1'b0, 1'b1, 333);
    run_window("R3 E1 short", 1'b1, 1'b1, 500);
    run_window("R2 T1 long", 1'b0, 1'b0, 8000);
    run_window("R2 E1 long", 1'b1, 1'b0, 8000);
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule